// File: doc/BRIEF.md
# SPI Master Serial Port

This block is a byte-wide SPI master. The host sees it as three registers on a small parallel bus. When the port is enabled and idle, a write to the data register starts a transfer. The block then drives a serial clock. It shifts the written byte out on `sdo`, most significant bit first, and collects the reply from `sdi` into the same shift register. After the last clock edge, the received byte replaces the data register contents. A buffer-full flag and an interrupt flag are raised at the same time.

The serial clock is taken from the system clock divided by 4, 16 or 64, or from an external timer pulse. In timer mode each pulse makes one serial clock edge. The idle level of the serial clock and the edge on which data is launched can both be programmed. A data write that arrives while a transfer is running is dropped and sets a sticky collision flag. Clearing the enable bit aborts any transfer at once and returns the pins to idle. Reconfiguration is done by disabling the port, rewriting the control register and enabling it again.

Register map (2-bit address):
- 0 is DATA.
- 1 is CTRL:
  - bit 4: enable
  - bit 3: launch-edge select
  - bit 2: clock idle level
  - bits 1:0: rate
- 2 is STAT:
  - bit 0: full
  - bit 1: interrupt
  - bit 2: collision
  - bit 3: busy
  - writing a 1 to bit 1 or bit 2 clears that flag.

Top module: `spi_host_port`

## Requirements
- R1: A DATA write while enabled and idle starts a transfer: STAT bit 3 reads 1 until exactly 16 serial clock edges have been produced, and then reads 0.
- R2: `sdo` carries the written byte MSB first. The bits seen on `sdi` are assembled MSB first, and after the transfer a DATA read returns the assembled byte.
- R3: At the end of a transfer, STAT bit 0 (full) and STAT bit 1 (interrupt) both become 1, and the `irq` output follows STAT bit 1.
- R4: A DATA read clears the full bit. The interrupt bit stays set until a STAT write with bit 1 set.
- R5: A DATA write during a transfer is ignored: the bits shifted out and the received result are unchanged. It sets STAT bit 2, which stays set until a STAT write with bit 2 set.
- R6: CTRL[1:0] selects the rate. Values 0, 1 and 2 give 2, 8 and 32 system clocks between serial clock edges. Value 3 gives one edge per `tmr_tick` pulse.
- R7: CTRL bit 2 is the level of `sck` whenever no transfer is running.
- R8: With CTRL bit 3 = 0, `sdo` holds the first bit before the first edge, changes only on edges that return `sck` to idle, and `sdi` is sampled on edges that leave idle. With bit 3 = 1 the two roles swap.
- R9: While CTRL bit 4 is 0, the port is held reset: no transfer runs, STAT reads 0, `sck` sits at its idle level and `sdo` is 0. DATA writes start nothing, and DATA keeps its last contents.
- R10: A DATA read during a transfer returns the byte written to start it. The shift register itself is never visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a DATA read clears full) |
| reg_addr | input | 2 | Register address: 0 DATA, 1 CTRL, 2 STAT |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| tmr_tick | input | 1 | External timer pulse, used when rate is 3 |
| sdi | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the slave |
| irq | output | 1 | Interrupt request, equal to the interrupt flag |

## Verification
A slave model in the bench sends a chosen reply byte while the scoreboard checks the byte it receives. The patterns are all-zeros against all-ones, alternating bits, and bytes whose end bits differ from their middle bits. These separate a reversed bit order and a stuck line from a lost first or last bit. All four rate codes are run, paired with both clock idle levels and both launch edges. The measured edge spacing separates the rates, and the launch-edge pairing exposes sampling on the wrong edge. A collision run and an abort-by-disable run check that dropped writes leave the shifted data, the buffer and the flags exactly as R5 and R9 require.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // Serial clock source select (CTRL[1:0])
  typedef enum logic [1:0] {
    RATE_DIV_A = 2'd0,
    RATE_DIV_B = 2'd1,
    RATE_DIV_C = 2'd2,
    RATE_TIMER = 2'd3
  } rate_e;

  // CTRL[4:0]: enable, launch-edge select, idle level, rate
  typedef struct packed {
    logic  en;
    logic  cpha;
    logic  cpol;
    rate_e rate;
  } ctrl_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/spi_host_rate.sv
module spi_host_rate
  import spi_host_pkg::*;
#(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  tick
);

  localparam int unsigned HALF_C = DIV_C / 2;
  localparam int unsigned CW     = (HALF_C > 1) ? $clog2(HALF_C) : 1;
  localparam logic [CW-1:0] LIM_A = CW'(DIV_A / 2 - 1);
  localparam logic [CW-1:0] LIM_B = CW'(DIV_B / 2 - 1);
  localparam logic [CW-1:0] LIM_C = CW'(DIV_C / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          wrap;

  always_comb begin
    case (rate)
      RATE_DIV_A: lim = LIM_A;
      RATE_DIV_B: lim = LIM_B;
      RATE_DIV_C: lim = LIM_C;
      default:    lim = '0;
    endcase
  end

  assign wrap = (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || rate == RATE_TIMER || wrap) cnt_d = '0;
    else                                    cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && ((rate == RATE_TIMER) ? tmr_tick : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  div_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != RATE_TIMER && $stable(rate)) |=> (!tick || rate == RATE_TIMER || !$stable(rate)));

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic              busy_q, busy_d;
  logic              phase_q, phase_d;
  logic              sdo_q, sdo_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              capture, last;

  assign capture = (!phase_q) ^ cpha;   // leading edge captures when cpha = 0
  assign last    = (edge_q == LAST);

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    sdo_d   = sdo_q;
    edge_d  = edge_q;
    sr_d    = sr_q;
    done    = 1'b0;
    if (!en) begin
      busy_d  = 1'b0;
      phase_d = 1'b0;
      sdo_d   = 1'b0;
      edge_d  = '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        phase_d = 1'b0;
        edge_d  = '0;
        sr_d    = load_data;
        if (!cpha) sdo_d = load_data[DATA_W-1];
      end
    end else if (tick) begin
      edge_d  = edge_q + 1'b1;
      phase_d = !phase_q;
      if (capture)    sr_d  = {sr_q[DATA_W-2:0], sdi};
      else if (!last) sdo_d = sr_q[DATA_W-1];
      if (last) begin
        busy_d = 1'b0;
        edge_d = '0;
        done   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      sdo_q   <= 1'b0;
      edge_q  <= '0;
      sr_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      sdo_q   <= sdo_d;
      edge_q  <= edge_d;
      sr_q    <= sr_d;
    end
  end

  assign sck     = phase_q ^ cpol;
  assign sdo     = sdo_q;
  assign busy    = busy_q;
  assign rx_data = sr_d;

  // R1
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q <= LAST));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == cpol));

  // R8
  lead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cpha && $stable(cpha) && $rose(phase_q)) |-> $stable(sdo_q));

endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_A  = 4,
  parameter int unsigned DIV_B  = 16,
  parameter int unsigned DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_tick,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              irq
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Reset: asserted asynchronously, released through two flops
  logic rs_a, rs_b, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  assign rst_i = rs_b;

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d, irq_q, irq_d, wcol_q, wcol_d;
  logic              wr_data, wr_ctrl, wr_stat, rd_data;
  logic              busy, done, tick, start;
  logic [DATA_W-1:0] rx_data;

  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign start   = wr_data && ctrl_q.en && !busy;

  spi_host_rate #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B),
    .DIV_C (DIV_C)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (busy),
    .rate     (ctrl_q.rate),
    .tmr_tick (tmr_tick),
    .tick     (tick)
  );

  spi_host_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_i),
    .en        (ctrl_q.en),
    .start     (start),
    .load_data (reg_wdata),
    .tick      (tick),
    .cpol      (ctrl_q.cpol),
    .cpha      (ctrl_q.cpha),
    .sdi       (sdi),
    .sck       (sck),
    .sdo       (sdo),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data)
  );

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;
    buf_d  = buf_q;
    full_d = full_q;
    irq_d  = irq_q;
    wcol_d = wcol_q;
    if (!ctrl_q.en) begin
      full_d = 1'b0;
      irq_d  = 1'b0;
      wcol_d = 1'b0;
    end else begin
      if (start)                   buf_d  = reg_wdata;
      if (wr_data && busy)         wcol_d = 1'b1;
      if (rd_data)                 full_d = 1'b0;
      if (wr_stat && reg_wdata[1]) irq_d  = 1'b0;
      if (wr_stat && reg_wdata[2]) wcol_d = 1'b0;
      if (done) begin
        buf_d  = rx_data;
        full_d = 1'b1;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      buf_q  <= buf_d;
      full_q <= full_d;
      irq_q  <= irq_d;
      wcol_q <= wcol_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_DATA: reg_rdata = buf_q;
      ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: reg_rdata[3:0] = {busy, wcol_q, irq_q, full_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R3
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> (full_q && irq_q));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_data && !done && ctrl_q.en) |=> !full_q);

  // R5
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_data && busy && ctrl_q.en) |=> wcol_q);

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !ctrl_q.en |=> (!busy && !sdo));

endmodule

// File: tb/spi_host_port_bench.sv
module spi_host_port_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tmr_tick, sdi, sck, sdo, irq;

  always #5 clk = ~clk;

  spi_host_port u_spi_host_port (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .tmr_tick (tmr_tick), .sdi (sdi), .sck (sck), .sdo (sdo), .irq (irq)
  );

  int     n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  int     tdiv = 0;

  always @(negedge clk) begin
    cyc++;
    tdiv     = (tdiv == 4) ? 0 : tdiv + 1;
    tmr_tick = (tdiv == 4);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Slave model and scoreboard of bytes expected on sdo
  logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
  logic [7:0] tx_q[$];
  int     edge_cnt = 0, cap_cnt = 0, gap_min = 0, gap_max = 0;
  longint last_cyc = 0;
  bit     xfer_on = 1'b0, cph = 1'b0;

  function automatic int idx_of(input int e, input bit c);
    int i;
    i = c ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
    if (i > 7) i = 7;
    return i;
  endfunction

  assign sdi = slv_tx[7 - idx_of(edge_cnt, cph)];

  always @(sck) begin
    if (xfer_on) begin
      edge_cnt++;
      if (edge_cnt > 1) begin
        if (int'(cyc - last_cyc) < gap_min) gap_min = int'(cyc - last_cyc);
        if (int'(cyc - last_cyc) > gap_max) gap_max = int'(cyc - last_cyc);
      end
      last_cyc = cyc;
      if (((edge_cnt % 2) == 1) ^ cph) begin
        slv_rx = {slv_rx[6:0], sdo};
        cap_cnt++;
        if (cap_cnt == 8) begin
          if (tx_q.size() == 0) check("R2 unexpected byte on sdo", {24'd0, slv_rx}, 32'hFFFF_FFFF);
          else check("R2/R5 byte seen on sdo", {24'd0, slv_rx}, {24'd0, tx_q.pop_front()});
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin
      bus_read(2'd2, s);
      n++;
    end while (s[3] && n < 5000);
  endtask

  task automatic run_xfer(input logic [1:0] rate, input bit pol, input bit pha,
                          input logic [7:0] tx, input logic [7:0] sl,
                          input int exp_gap, input bit collide);
    logic [7:0] d, s;
    bus_write(2'd1, {3'b000, 1'b1, pha, pol, rate});
    repeat (2) @(negedge clk);
    check("R7 idle sck level", {31'd0, sck}, {31'd0, pol});
    cph = pha; slv_tx = sl; edge_cnt = 0; cap_cnt = 0;
    gap_min = 1000000; gap_max = 0;
    tx_q.push_back(tx);
    xfer_on = 1'b1;
    bus_write(2'd0, tx);
    if (collide) begin
      repeat (3) @(negedge clk);
      bus_write(2'd0, ~tx);
      bus_read(2'd0, d);
      check("R10 buffer read mid-transfer", {24'd0, d}, {24'd0, tx});
      bus_read(2'd2, s);
      check("R5 collision flag and busy", {28'd0, s[3:2]}, 32'd3);
    end
    wait_idle();
    xfer_on = 1'b0;
    check("R1 serial clock edge count", edge_cnt, 16);
    check("R6 min edge spacing", gap_min, exp_gap);
    check("R6 max edge spacing", gap_max, exp_gap);
    bus_read(2'd2, s);
    check("R3 full and interrupt set", {30'd0, s[1:0]}, 32'd3);
    check("R3 irq pin", {31'd0, irq}, 32'd1);
    bus_read(2'd0, d);
    check("R2/R8 received byte", {24'd0, d}, {24'd0, sl});
    bus_read(2'd2, s);
    check("R4 full cleared, interrupt kept", {30'd0, s[1:0]}, 32'd2);
    if (collide) check("R5 collision flag sticky", {31'd0, s[2]}, 32'd1);
    bus_write(2'd2, 8'h06);
    bus_read(2'd2, s);
    check("R4/R5 flags cleared by write", {29'd0, s[2:0]}, 32'd0);
    check("R4 irq pin low", {31'd0, irq}, 32'd0);
  endtask

  task automatic abort_test();
    logic [7:0] d, s;
    bus_write(2'd1, {3'b000, 1'b1, 1'b0, 1'b1, 2'd2});
    cph = 1'b0; slv_tx = 8'h3C; edge_cnt = 0; cap_cnt = 0;
    xfer_on = 1'b1;
    bus_write(2'd0, 8'h5A);
    repeat (60) @(negedge clk);
    bus_write(2'd0, 8'h11);
    xfer_on = 1'b0;
    bus_write(2'd1, {3'b000, 1'b0, 1'b0, 1'b1, 2'd2});
    bus_read(2'd2, s);
    check("R9 STAT cleared on disable", {24'd0, s}, 32'd0);
    check("R9 sck idle when disabled", {31'd0, sck}, 32'd1);
    check("R9 sdo low when disabled", {31'd0, sdo}, 32'd0);
    bus_write(2'd0, 8'h77);
    repeat (40) @(negedge clk);
    bus_read(2'd2, s);
    check("R9 no transfer while disabled", {24'd0, s}, 32'd0);
    check("R9 sck still idle", {31'd0, sck}, 32'd1);
    bus_read(2'd0, d);
    check("R9 buffer keeps last accepted byte", {24'd0, d}, 32'h5A);
  endtask

  task automatic all_tests();
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(2'd2, d); check("R9 reset STAT", {24'd0, d}, 32'd0);
    bus_read(2'd1, d); check("R9 reset CTRL", {24'd0, d}, 32'd0);
    bus_read(2'd0, d); check("R9 reset DATA", {24'd0, d}, 32'd0);
    check("R7 reset sck", {31'd0, sck}, 32'd0);
    check("R3 reset irq", {31'd0, irq}, 32'd0);
    run_xfer(2'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 2, 1'b0);
    run_xfer(2'd1, 1'b1, 1'b0, 8'hA5, 8'h5A, 8, 1'b0);
    run_xfer(2'd2, 1'b0, 1'b1, 8'h81, 8'h7E, 32, 1'b0);
    run_xfer(2'd3, 1'b1, 1'b1, 8'hC3, 8'h3C, 5, 1'b0);
    run_xfer(2'd1, 1'b0, 1'b1, 8'hFF, 8'h00, 8, 1'b1);
    abort_test();
    tx_q.delete();
    run_xfer(2'd0, 1'b1, 1'b0, 8'h96, 8'h69, 2, 1'b1);
  endtask

  initial begin
    fork
      all_tests();
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule